// File: doc/BRIEF.md
# Two-Wire Serial Memory Target (256 x 8)

This block is a two-wire bus target that appears on the bus as a 256-byte memory. Every byte has its own word address. Its storage is a synchronous RAM inside the block. The block watches the open-drain clock and data lines and answers only while it is addressed. It writes to the bus only by pulling the data line low. The block never stretches the clock.

A controller starts a transfer with a control byte. That byte holds a fixed device code, the three strap bits of this instance, and a direction bit. Write transfers set an address pointer and then store data bytes. A write is not placed into memory straight away: the data bytes are held in an 8-byte page staging buffer. A stop condition commits the buffer. Commit starts a timed busy window, and during that window the block refuses its own address, so a controller can poll until the write is done. Read transfers return bytes from the pointer. The pointer can be set by a dummy write followed by a repeated start, or used as it stands. Reads go on for as long as the controller acknowledges each byte.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the block does not pull the data line low, and it stays released while the bus is idle.
- R2: The block acknowledges a control byte only when bits 7:4 equal the device code (default 4'b1010) and bits 3:1 equal `dev_sel`. Bit 0 is the direction: 0 for write, 1 for read. It acknowledges by pulling data low in the ninth clock. On a mismatch it leaves the data line released for the ninth clock and for all later clocks until the next start.
- R3: A write transfer acknowledges the control byte, the word address byte and each data byte. After the stop and the busy window, a byte written to address A reads back from address A.
- R4: Within one write, the data bytes advance only the low three address bits. A ninth or later byte therefore wraps inside the same 8-byte page, and the last byte written to each slot is the one kept.
- R5: A stop that ends a write holding at least one complete data byte starts a busy window of `WRITE_CYCLES` clocks. During the window every control byte gets no acknowledge. After the window the control byte is acknowledged again.
- R6: Staged data reaches memory only at a stop. A repeated start issued before the stop throws the staged bytes away and starts no busy window.
- R7: A random read (start, write control byte, word address, repeated start, read control byte) returns the byte stored at that word address.
- R8: During a read, an acknowledge from the controller makes the block send the next byte. The pointer goes up by one after each byte sent and wraps from 0xFF to 0x00, with no page limit.
- R9: A read control byte sent without a word address returns the byte at the current pointer. After a read, the pointer is one past the last byte sent. After a write, it is one past the last data slot, counted within the page.
- R10: A start or stop condition seen in any state restarts byte reception. A stop in the middle of a byte leaves the block ready for the next start. A start in the middle of a byte begins a new control byte.
- R11: The block changes its data drive only while the clock line is low, so every data bit it sends is stable throughout the clock-high time.
- R12: A non-acknowledge from the controller after a read byte ends the read. The data line then stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 3 | Strap bits that must match control byte bits 3:1 |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong byte-level state usually shows up at the ninth clock of the affected byte: an acknowledge missing or added where the reference expects the opposite. Every clock-high cycle compares the data drive against the reference, so such an error is caught within one bus bit time. A wrong address pointer or wrong staging contents does not appear until a later read. That read returns the wrong byte at the first bit that differs, which is why every write is followed by read-back covering the page wrap, the 0xFF wrap and the current-address path. A mistake in the busy window appears as a wrong acknowledge on the polling control byte, one poll sent inside the window and one after it.

// File: rtl/eeprom_pkg.sv
// Shared types for the two-wire memory target.
// Assumes 8-bit bus bytes; the state encoding is internal only.
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } link_state_e;

endpackage

// File: rtl/eeprom_line_sense.sv
// Brings the bus clock and data lines into the clk domain and reports
// edges and bus conditions. Assumes the bus clock is much slower than
// clk so each bus phase spans several clk cycles.
module eeprom_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;
    logic             scl_prev;
    logic             sda_prev;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
        end
    end

    assign scl_lvl   = scl_pipe[DEPTH-2];
    assign sda_lvl   = sda_pipe[DEPTH-2];
    assign scl_prev  = scl_pipe[DEPTH-1];
    assign sda_prev  = sda_pipe[DEPTH-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/eeprom_ram.sv
// Single-clock RAM with one write port and one registered read port.
// Contents are not reset; the read port re-reads its address each cycle.
module eeprom_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Write when asked and refresh the read register every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eeprom_page_buffer.sv
// Holds the data bytes of one write transfer, one slot per page offset,
// and copies the valid slots into RAM one per cycle once commit is given.
// Assumes the caller keeps commit inside a busy window of at least
// 2**PAGE_BITS cycles and sends no loads while committing.
module eeprom_page_buffer #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          commit,
    output logic          pending,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata
);
    localparam int SLOTS = 1 << PAGE_BITS;
    localparam int TAG_W = AW - PAGE_BITS;
    localparam logic [PAGE_BITS-1:0] LAST_SLOT = '1;
    localparam logic [PAGE_BITS-1:0] SLOT_ONE  = 1;

    logic [DW-1:0]        slot_data [SLOTS];
    logic [SLOTS-1:0]     slot_valid;
    logic [TAG_W-1:0]     page_tag;
    logic                 committing;
    logic [PAGE_BITS-1:0] walk;

    // Capture incoming bytes, drop them on clear, drain them on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= '0;
            page_tag   <= '0;
            committing <= 1'b0;
            walk       <= '0;
        end else if (committing) begin
            walk <= walk + SLOT_ONE;
            if (walk == LAST_SLOT) begin
                committing <= 1'b0;
                slot_valid <= '0;
            end
        end else if (commit) begin
            committing <= 1'b1;
            walk       <= '0;
        end else if (clear) begin
            slot_valid <= '0;
        end else if (load) begin
            slot_valid[load_addr[PAGE_BITS-1:0]] <= 1'b1;
            page_tag                             <= load_addr[AW-1:PAGE_BITS];
        end
    end

    // Slot payload storage, written only on accepted loads.
    always_ff @(posedge clk) begin
        if (load && !committing && !commit && !clear) begin
            slot_data[load_addr[PAGE_BITS-1:0]] <= load_data;
        end
    end

    assign pending   = (|slot_valid) & ~committing;
    assign ram_we    = committing & slot_valid[walk];
    assign ram_waddr = {page_tag, walk};
    assign ram_wdata = slot_data[walk];

endmodule

// File: rtl/eeprom_write_timer.sv
// Counts out the internal write window. Busy is high for exactly CYCLES
// clk cycles after the cycle in which go is seen.
module eeprom_write_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;

    logic [CNT_W-1:0] remain;

    // Load on go, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (go) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - CNT_ONE;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/serial_eeprom_slave.sv
// Two-wire bus target presenting a 256 x 8 memory. Decodes the control
// byte, keeps the address pointer, stages page writes, commits them at a
// stop and refuses its address during the write window. Assumes clk is
// at least 8x faster than the bus clock and WRITE_CYCLES >= 2**PAGE_BITS.
module serial_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int          AW           = 8,
    parameter int          DW           = 8,
    parameter int          PAGE_BITS    = 3,
    parameter logic [3:0]  DEV_CODE     = 4'b1010,
    parameter int          WRITE_CYCLES = 2000,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] dev_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0]     BYTE_BITS = CNT_W'(DW);
    localparam logic [CNT_W-1:0]     LAST_BIT  = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0]     CNT_ONE   = 1;
    localparam logic [AW-1:0]        ADDR_ONE  = 1;
    localparam logic [PAGE_BITS-1:0] OFF_ONE   = 1;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    link_state_e      state;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    rx_sh;
    logic [DW-1:0]    tx_sh;
    logic [AW-1:0]    addr_ptr;
    logic             rd_req;
    logic             master_nack;

    logic          busy;
    logic          buf_pending;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;

    logic rx_done;
    logic ctrl_hit;
    logic buf_load;
    logic commit_go;

    eeprom_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Byte-level decode helpers shared by the FSM and the staging buffer.
    assign rx_done   = scl_fall && (bit_cnt == BYTE_BITS);
    assign ctrl_hit  = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == dev_sel) && !busy;
    assign buf_load  = !start_det && !stop_det && (state == ST_WDATA) && rx_done;
    assign commit_go = stop_det && buf_pending;

    eeprom_page_buffer #(.AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_det),
        .load      (buf_load),
        .load_addr (addr_ptr),
        .load_data (rx_sh),
        .commit    (commit_go),
        .pending   (buf_pending),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    eeprom_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (commit_go),
        .busy  (busy)
    );

    eeprom_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (addr_ptr),
        .rdata (ram_rdata)
    );

    // Bus protocol state machine: bit reception, acknowledges and read shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            addr_ptr    <= '0;
            rd_req      <= 1'b0;
            master_nack <= 1'b0;
            sda_pull    <= 1'b0;
        end else if (start_det) begin
            state    <= ST_CTRL;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_CTRL: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_ONE;
                    end else if (rx_done) begin
                        bit_cnt <= '0;
                        if (ctrl_hit) begin
                            sda_pull <= 1'b1;
                            rd_req   <= rx_sh[0];
                            state    <= ST_CTRL_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_ONE;
                    end else if (rx_done) begin
                        bit_cnt  <= '0;
                        addr_ptr <= rx_sh;
                        sda_pull <= 1'b1;
                        state    <= ST_WADDR_ACK;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_ONE;
                    end else if (rx_done) begin
                        bit_cnt  <= '0;
                        addr_ptr <= {addr_ptr[AW-1:PAGE_BITS], addr_ptr[PAGE_BITS-1:0] + OFF_ONE};
                        sda_pull <= 1'b1;
                        state    <= ST_WDATA_ACK;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rd_req) begin
                            tx_sh    <= ram_rdata;
                            sda_pull <= ~ram_rdata[DW-1];
                            addr_ptr <= addr_ptr + ADDR_ONE;
                            bit_cnt  <= '0;
                            state    <= ST_RDATA;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_RACK;
                        end else begin
                            bit_cnt  <= bit_cnt + CNT_ONE;
                            tx_sh    <= {tx_sh[DW-2:0], 1'b0};
                            sda_pull <= ~tx_sh[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        master_nack <= sda_lvl;
                    end else if (scl_fall) begin
                        if (!master_nack) begin
                            tx_sh    <= ram_rdata;
                            sda_pull <= ~ram_rdata[DW-1];
                            addr_ptr <= addr_ptr + ADDR_ONE;
                            bit_cnt  <= '0;
                            state    <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/eeprom_slave_checker.sv
// Protocol and timing properties of the memory target, bound to the top.
// Assumes reset is held for at least one clock at time zero.
module eeprom_slave_checker
    import eeprom_pkg::*;
#(
    parameter int WRITE_CYCLES = 2000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_lvl,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_pull,
    input logic        busy,
    input logic        ram_we,
    input link_state_e state
);
    localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

    logic [RUN_W-1:0] busy_run;

    // Measure how long each busy window lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == RUN_W'(WRITE_CYCLES)))
        else $error("busy window length wrong");

    assert_commit_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy)
        else $error("memory written outside busy window");

    assert_drive_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl)
        else $error("data pulled low while clock high");

    assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull)
        else $error("data still pulled after stop");

    assert_release_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull)
        else $error("data still pulled after start");

    assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull)
        else $error("data pulled while idle");

endmodule

bind serial_eeprom_slave eeprom_slave_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .busy      (busy),
    .ram_we    (ram_we),
    .state     (state)
);

// File: tb/sim_serial_eeprom_slave.sv
// Bench for the memory target: a bus controller model with a behavioural
// memory, pointer and busy-window reference compared on every clock.
`timescale 1ns/1ps
module sim_serial_eeprom_slave;

    localparam int WC = 400;
    localparam int Q  = 5;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] CTRL_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] CTRL_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic exp_oe = 1'b0;
    logic sda_pull;
    logic sda_line;
    string cur_req = "R1";
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr = 8'h00;
    logic [7:0] vals [16];

    assign sda_line = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    serial_eeprom_slave #(.WRITE_CYCLES(WC)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_sel  (SEL),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_pull (sda_pull)
    );

    // Per-clock comparison of the data drive against the reference while the clock is high.
    always @(negedge clk) begin
        if (rst_n && scl_m && !done) begin
            checks++;
            if (sda_pull !== exp_oe) begin
                errors++;
                $display("FAIL %s/R11 data drive at %0t: got %0b expected %0b", cur_req, $time, sda_pull, exp_oe);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bit_slot(input logic d, input logic eo, output logic seen);
        wait_clk(Q);
        sda_m  = d;
        exp_oe = eo;
        wait_clk(Q);
        scl_m = 1'b1;
        wait_clk(Q);
        seen = sda_line;
        wait_clk(Q);
        scl_m = 1'b0;
    endtask

    task automatic start_cond();
        if (!scl_m) begin
            wait_clk(Q);
            sda_m  = 1'b1;
            exp_oe = 1'b0;
            wait_clk(Q);
            scl_m = 1'b1;
            wait_clk(Q);
        end else begin
            exp_oe = 1'b0;
        end
        sda_m = 1'b0;
        wait_clk(Q);
        scl_m = 1'b0;
    endtask

    task automatic stop_cond();
        wait_clk(Q);
        sda_m  = 1'b0;
        exp_oe = 1'b0;
        wait_clk(Q);
        scl_m = 1'b1;
        wait_clk(Q);
        sda_m = 1'b1;
        wait_clk(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) bit_slot(b[i], 1'b0, s);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic s;
        send_bits(b, 8);
        bit_slot(1'b1, exp_ack, s);
        check(req, "acknowledge level", s, exp_ack ? 0 : 1);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit give_ack, input string req);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, ~exp[i], s);
            got[i] = s;
        end
        bit_slot(give_ack ? 1'b0 : 1'b1, 1'b0, s);
        check(req, "read byte", got, exp);
    endtask

    // Full write transfer of n bytes from vals; reference staged then committed at stop.
    task automatic write_seq(input logic [7:0] addr, input int n, input string req);
        logic [7:0] p;
        cur_req = req;
        start_cond();
        send_byte(CTRL_W, 1'b1, req);
        send_byte(addr, 1'b1, req);
        p = addr;
        for (int k = 0; k < n; k++) begin
            send_byte(vals[k], 1'b1, req);
            ref_mem[p] = vals[k];
            p = {p[7:3], p[2:0] + 3'd1};
        end
        ref_ptr = p;
        stop_cond();
    endtask

    task automatic read_random(input logic [7:0] addr, input int n, input string req);
        cur_req = req;
        start_cond();
        send_byte(CTRL_W, 1'b1, req);
        send_byte(addr, 1'b1, req);
        ref_ptr = addr;
        start_cond();
        send_byte(CTRL_R, 1'b1, req);
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_ptr], k < n - 1, req);
            ref_ptr = ref_ptr + 8'd1;
        end
        stop_cond();
    endtask

    task automatic read_current(input int n, input string req);
        cur_req = req;
        start_cond();
        send_byte(CTRL_R, 1'b1, req);
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_ptr], k < n - 1, req);
            ref_ptr = ref_ptr + 8'd1;
        end
        stop_cond();
    endtask

    task automatic poll(input bit exp_ack, input string req);
        cur_req = req;
        start_cond();
        send_byte(CTRL_W, exp_ack, req);
        stop_cond();
    endtask

    initial begin
        logic s;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1", "drive after reset", sda_pull, 0);
        wait_clk(20);

        // R2: wrong device code, then wrong strap followed by an ignored matching byte
        cur_req = "R2";
        start_cond();
        send_byte(8'hBA, 1'b0, "R2");
        stop_cond();
        start_cond();
        send_byte({4'b1010, 3'b011, 1'b0}, 1'b0, "R2");
        send_byte(CTRL_W, 1'b0, "R2");
        stop_cond();

        // R3 byte write, then R5 poll inside and after the busy window
        vals[0] = 8'h5C;
        write_seq(8'h10, 1, "R3");
        poll(1'b0, "R5");
        wait_clk(WC + 40);
        poll(1'b1, "R5");

        // R7 random read; R12 extra clocks after the controller's NACK
        cur_req = "R7";
        start_cond();
        send_byte(CTRL_W, 1'b1, "R7");
        send_byte(8'h10, 1'b1, "R7");
        start_cond();
        send_byte(CTRL_R, 1'b1, "R7");
        recv_byte(ref_mem[8'h10], 1'b0, "R7");
        ref_ptr = 8'h11;
        cur_req = "R12";
        bit_slot(1'b1, 1'b0, s);
        check("R12", "line after nack", s, 1);
        bit_slot(1'b0, 1'b0, s);
        stop_cond();

        // R4 ten bytes into page 0x20 starting at 0x23
        for (int k = 0; k < 10; k++) vals[k] = 8'hD0 + 8'(k);
        write_seq(8'h23, 10, "R4");
        wait_clk(WC + 40);
        read_random(8'h20, 8, "R4");

        // R6 staged byte discarded by repeated start; R9 current read from pointer
        cur_req = "R6";
        start_cond();
        send_byte(CTRL_W, 1'b1, "R6");
        send_byte(8'h24, 1'b1, "R6");
        send_byte(8'hEE, 1'b1, "R6");
        ref_ptr = 8'h25;
        start_cond();
        send_byte(CTRL_R, 1'b1, "R9");
        recv_byte(ref_mem[ref_ptr], 1'b0, "R9");
        ref_ptr = ref_ptr + 8'd1;
        stop_cond();
        poll(1'b1, "R6");
        read_random(8'h24, 1, "R6");

        // R8 sequential read across 0xFF -> 0x00
        for (int k = 0; k < 8; k++) vals[k] = 8'hF0 + 8'(k);
        write_seq(8'hF8, 8, "R8");
        wait_clk(WC + 40);
        for (int k = 0; k < 8; k++) vals[k] = 8'hA0 + 8'(k);
        write_seq(8'h00, 8, "R8");
        wait_clk(WC + 40);
        read_random(8'hFE, 4, "R8");
        read_current(1, "R9");

        // R10 stop in mid byte, then start in mid byte
        cur_req = "R10";
        start_cond();
        send_bits(CTRL_W, 4);
        stop_cond();
        poll(1'b1, "R10");
        cur_req = "R10";
        start_cond();
        send_byte(CTRL_W, 1'b1, "R10");
        send_byte(8'h21, 1'b1, "R10");
        ref_ptr = 8'h21;
        send_bits(8'h00, 3);
        start_cond();
        send_byte(CTRL_R, 1'b1, "R10");
        recv_byte(ref_mem[ref_ptr], 1'b0, "R10");
        ref_ptr = ref_ptr + 8'd1;
        stop_cond();
        poll(1'b1, "R10");

        wait_clk(20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule